// File: doc/BRIEF.md
# Stack-processor opcode decoder

This block sits beside the fetch stage of a small 32-bit stack processor. Each cycle on which `in_valid` is high, it takes one 8-bit opcode. One cycle later it presents the opcode's class, the stack slot and byte offset it names, and its sub-operation index. It also flags the special short forms for slots 0 and 1, and it marks opcodes that fall outside the defined operation set.

Immediate opcodes carry a 7-bit payload, and a long constant is built from a run of them. The decoder keeps a 32-bit accumulator and a chaining flag for this purpose. The first immediate of a run sign-extends its payload into the accumulator. Each immediate that follows directly shifts the accumulator left by seven bits and appends its payload. Any other valid opcode ends the run. Cycles without `in_valid` leave all decoder state untouched.

Top module: `stk_opdec`

## Requirements
- R1: The class is chosen from the opcode as follows. Bit 7 = 1 gives immediate (class code 5). Otherwise, bits 7..5 = 010 give store-offset (2), 011 give load-offset (3) and 001 give emulated (4). Bits 7..4 = 0001 give add-offset (1), and bits 7..4 = 0000 give short (0).
- R2: For store, load and add opcodes, `slot_off` is {NOT bit 4, bits 3..0} and `byte_off` is four times that value. Both are zero for the other classes.
- R3: `form0` is high when a store, load or add opcode has slot 0, and `form1` is high when it has slot 1. Neither is high for any other opcode.
- R4: `sub_op` gives opcode bits 5..0 for emulated opcodes and bits 3..0, zero-extended, for short opcodes. It is zero for the other classes.
- R5: `bad_op` is high for short codes 1, 3, 14 and 15, and for emulated sub-opcodes below 34 or above 60. It is low for every other opcode.
- R6: An immediate opcode that does not follow another immediate loads `imm_value` with its bits 6..0 sign-extended to 32 bits, and drives `imm_chained` low.
- R7: An immediate opcode that follows another immediate loads `imm_value` with the previous value shifted left by 7, with its own bits 6..0 placed in bits 6..0, and drives `imm_chained` high.
- R8: A valid non-immediate opcode ends the immediate run and leaves `imm_value` unchanged. Idle cycles between two immediates do not end the run.
- R9: All outputs take effect on the first clock edge after the opcode is presented. `out_valid` is high for exactly the cycle after each valid input cycle.
- R10: While `in_valid` is low, every output except `out_valid` holds its value.
- R11: Synchronous reset clears every output, the accumulator and the chaining flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Opcode strobe |
| opcode | input | 8 | Instruction byte |
| out_valid | output | 1 | Decoded result present |
| op_class | output | 3 | Class code |
| slot_off | output | 5 | Stack slot offset |
| byte_off | output | 7 | Stack byte offset |
| sub_op | output | 6 | Emulated or short operation index |
| form0 | output | 1 | Slot-0 special form |
| form1 | output | 1 | Slot-1 special form |
| bad_op | output | 1 | Opcode outside the defined set |
| imm_value | output | 32 | Running immediate value |
| imm_chained | output | 1 | Last immediate extended a run |

## Verification
The bound checker watches on every cycle that `out_valid` tracks the strobe by one cycle and that idle cycles freeze the class and the accumulator. It also checks that every immediate is classified as such, that a chained immediate shifts and appends, that a non-immediate drops the chain, and that the form and invalid flags never coincide. The exact offset, sub-opcode and invalid-set values for each opcode can only be shown by the bench's vector table. The same holds for the sign extension at the start of a run, the loss of upper bits in long runs, chain survival across idle gaps, and the clearing effect of reset.

// File: rtl/stk_opdec.sv
module stk_opdec #(
  parameter int          ACC_W    = 32,
  parameter int          EMU_LO   = 34,
  parameter int          EMU_HI   = 60,
  parameter logic [15:0] SHORT_OK = 16'h3FF5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       opcode,
  output logic             out_valid,
  output logic [2:0]       op_class,
  output logic [4:0]       slot_off,
  output logic [6:0]       byte_off,
  output logic [5:0]       sub_op,
  output logic             form0,
  output logic             form1,
  output logic             bad_op,
  output logic [ACC_W-1:0] imm_value,
  output logic             imm_chained
);
  localparam int PAY_W = 7;
  localparam int EXT_W = ACC_W - PAY_W;

  localparam logic [2:0] CL_SHORT = 3'd0;
  localparam logic [2:0] CL_ADD   = 3'd1;
  localparam logic [2:0] CL_STORE = 3'd2;
  localparam logic [2:0] CL_LOAD  = 3'd3;
  localparam logic [2:0] CL_EMU   = 3'd4;
  localparam logic [2:0] CL_IMM   = 3'd5;

  logic [2:0]       cls;
  logic [4:0]       slot_raw;
  logic             has_slot;
  logic [5:0]       sub_d;
  logic             bad_d;
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             chain_q;
  logic             is_imm;

  assign is_imm   = opcode[7];
  assign slot_raw = {~opcode[4], opcode[3:0]};

  always_comb begin
    if (is_imm)                  cls = CL_IMM;
    else if (opcode[6:5] == 2'b10) cls = CL_STORE;
    else if (opcode[6:5] == 2'b11) cls = CL_LOAD;
    else if (opcode[6:5] == 2'b01) cls = CL_EMU;
    else if (opcode[4])          cls = CL_ADD;
    else                         cls = CL_SHORT;
  end

  assign has_slot = (cls == CL_STORE) || (cls == CL_LOAD) || (cls == CL_ADD);

  always_comb begin
    sub_d = '0;
    bad_d = 1'b0;
    case (cls)
      CL_EMU: begin
        sub_d = opcode[5:0];
        bad_d = (int'(opcode[5:0]) < EMU_LO) || (int'(opcode[5:0]) > EMU_HI);
      end
      CL_SHORT: begin
        sub_d = {2'b00, opcode[3:0]};
        bad_d = ~SHORT_OK[opcode[3:0]];
      end
      default: ;
    endcase
  end

  assign acc_d = chain_q ? {acc_q[ACC_W-PAY_W-1:0], opcode[PAY_W-1:0]}
                         : {{EXT_W{opcode[PAY_W-1]}}, opcode[PAY_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      op_class    <= CL_SHORT;
      slot_off    <= '0;
      byte_off    <= '0;
      sub_op      <= '0;
      form0       <= 1'b0;
      form1       <= 1'b0;
      bad_op      <= 1'b0;
      imm_chained <= 1'b0;
      acc_q       <= '0;
      chain_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        op_class    <= cls;
        slot_off    <= has_slot ? slot_raw : 5'd0;
        byte_off    <= has_slot ? {slot_raw, 2'b00} : 7'd0;
        sub_op      <= sub_d;
        form0       <= has_slot && (slot_raw == 5'd0);
        form1       <= has_slot && (slot_raw == 5'd1);
        bad_op      <= bad_d;
        imm_chained <= is_imm && chain_q;
        chain_q     <= is_imm;
        if (is_imm) acc_q <= acc_d;
      end
    end
  end

  assign imm_value = acc_q;
endmodule

// File: rtl/stk_opdec_chk.sv
module stk_opdec_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  opcode,
  input logic        out_valid,
  input logic [2:0]  op_class,
  input logic        form0,
  input logic        form1,
  input logic        bad_op,
  input logic [31:0] imm_value,
  input logic        chain_q
);
  assert_out_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_out_drops_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_imm_class_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7]) |=> (op_class == 3'd5));
  assert_chain_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && opcode[7] && chain_q) |=>
      (imm_value == {$past(imm_value[24:0]), $past(opcode[6:0])}));
  assert_chain_break_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !opcode[7]) |=> (!chain_q && $stable(imm_value)));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(imm_value) && $stable(op_class) && $stable(chain_q)));
  assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({form0, form1, bad_op}));
endmodule

bind stk_opdec stk_opdec_chk chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
  .out_valid(out_valid), .op_class(op_class), .form0(form0), .form1(form1),
  .bad_op(bad_op), .imm_value(imm_value), .chain_q(chain_q)
);

// File: tb/stk_opdec_test.sv
`timescale 1ns/1ps
module stk_opdec_test;
  localparam real CYC = 20.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        out_valid;
  logic [2:0]  op_class;
  logic [4:0]  slot_off;
  logic [6:0]  byte_off;
  logic [5:0]  sub_op;
  logic        form0, form1, bad_op;
  logic [31:0] imm_value;
  logic        imm_chained;

  int errors = 0;
  int checks = 0;

  always #(CYC/2) clk = ~clk;

  stk_opdec uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode),
    .out_valid(out_valid), .op_class(op_class), .slot_off(slot_off),
    .byte_off(byte_off), .sub_op(sub_op), .form0(form0), .form1(form1),
    .bad_op(bad_op), .imm_value(imm_value), .imm_chained(imm_chained)
  );

  // {opcode, class, slot, sub, form0, form1, bad}
  localparam int NV = 19;
  localparam logic [24:0] TV [NV] = '{
    {8'h50, 3'd2, 5'd0,  6'd0,  3'b100},
    {8'h51, 3'd2, 5'd1,  6'd0,  3'b010},
    {8'h43, 3'd2, 5'd19, 6'd0,  3'b000},
    {8'h5F, 3'd2, 5'd15, 6'd0,  3'b000},
    {8'h70, 3'd3, 5'd0,  6'd0,  3'b100},
    {8'h71, 3'd3, 5'd1,  6'd0,  3'b010},
    {8'h6F, 3'd3, 5'd31, 6'd0,  3'b000},
    {8'h10, 3'd1, 5'd0,  6'd0,  3'b100},
    {8'h11, 3'd1, 5'd1,  6'd0,  3'b010},
    {8'h1A, 3'd1, 5'd10, 6'd0,  3'b000},
    {8'h22, 3'd4, 5'd0,  6'd34, 3'b000},
    {8'h3C, 3'd4, 5'd0,  6'd60, 3'b000},
    {8'h20, 3'd4, 5'd0,  6'd32, 3'b001},
    {8'h3F, 3'd4, 5'd0,  6'd63, 3'b001},
    {8'h00, 3'd0, 5'd0,  6'd0,  3'b000},
    {8'h05, 3'd0, 5'd0,  6'd5,  3'b000},
    {8'h0D, 3'd0, 5'd0,  6'd13, 3'b000},
    {8'h01, 3'd0, 5'd0,  6'd1,  3'b001},
    {8'h0E, 3'd0, 5'd0,  6'd14, 3'b001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive one opcode for one cycle; return at the negedge after the capturing edge
  task automatic send(input logic [7:0] op);
    @(negedge clk);
    in_valid = 1'b1;
    opcode   = op;
    @(negedge clk);
    in_valid = 1'b0;
    opcode   = 8'hAA;
  endtask

  initial begin
    #(CYC * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 out_valid", 32'(out_valid), 0);
    chk("R11 class", 32'(op_class), 0);
    chk("R11 imm_value", imm_value, 0);
    chk("R11 flags", {27'd0, form0, form1, bad_op, imm_chained, slot_off != 0}, 0);

    // R1 R2 R3 R4 R5 vector table
    for (int i = 0; i < NV; i++) begin
      send(TV[i][24:17]);
      chk("R9 out_valid", 32'(out_valid), 1);
      chk("R1 class", 32'(op_class), 32'(TV[i][16:14]));
      chk("R2 slot", 32'(slot_off), 32'(TV[i][13:9]));
      chk("R2 byte", 32'(byte_off), 32'(TV[i][13:9]) * 4);
      chk("R4 sub", 32'(sub_op), 32'(TV[i][8:3]));
      chk("R3 forms", {30'd0, form0, form1}, 32'(TV[i][2:1]));
      chk("R5 bad", 32'(bad_op), 32'(TV[i][0]));
    end

    // R9 strobe lasts one cycle only
    @(negedge clk);
    chk("R9 out_valid low", 32'(out_valid), 0);

    // R6 fresh positive immediate
    send(8'h85);
    chk("R1 imm class", 32'(op_class), 5);
    chk("R6 imm", imm_value, 32'h5);
    chk("R6 chained", 32'(imm_chained), 0);
    // R7 chained
    send(8'hFF);
    chk("R7 imm", imm_value, 32'h2FF);
    chk("R7 chained", 32'(imm_chained), 1);
    // R10 idle hold
    repeat (4) @(negedge clk);
    chk("R10 imm hold", imm_value, 32'h2FF);
    chk("R10 class hold", 32'(op_class), 5);
    // R8 chain survives idle
    send(8'h81);
    chk("R8 idle keeps chain", imm_value, 32'h17F81);
    // R8 non-immediate breaks chain, value unchanged
    send(8'h05);
    chk("R8 value kept", imm_value, 32'h17F81);
    chk("R8 class short", 32'(op_class), 0);
    // R6 negative fresh
    send(8'hC0);
    chk("R6 sign extend", imm_value, 32'hFFFFFFC0);
    chk("R6 chained low", 32'(imm_chained), 0);
    // R7 back-to-back run pushes upper bits out
    @(negedge clk);
    in_valid = 1'b1; opcode = 8'h80;
    @(negedge clk);
    chk("R7 run 1", imm_value, 32'hFFFFE000);
    @(negedge clk);
    chk("R7 run 2", imm_value, 32'hFFF00000);
    @(negedge clk);
    chk("R7 run 3", imm_value, 32'hF8000000);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R7 run 4", imm_value, 32'h0);
    chk("R9 out_valid run", 32'(out_valid), 1);

    // R11 reset clears chain and accumulator mid-run
    send(8'hFF);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 imm cleared", imm_value, 0);
    chk("R11 out_valid", 32'(out_valid), 0);
    send(8'h81);
    chk("R11 fresh after reset", imm_value, 32'h1);
    chk("R11 chained low", 32'(imm_chained), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule